// File: doc/BRIEF.md
# MOESI Line Coherence Controller

This block tracks the coherence state of every line in one core's private L1 cache in a snooping multicore system that uses five line states: Modified, Owned, Exclusive, Shared and Invalid. Each cycle it accepts at most one local operation from the core (a read, a write, or a replacement eviction) and at most one snooped bus transaction issued by another core (a read or a write). It updates the state of the addressed lines and drives that cycle's coherence actions. These actions are a read notification or a write notification for the local operation, a data supply when another core reads a line held dirty here, and a writeback request toward the shared L2 when a dirty copy is dropped.

The Owned state is the distinguishing feature. A line written locally and later read by another core is not cleaned through L2. It stays dirty in this cache, and this cache keeps supplying it to later readers. The copy goes back to L2 only when it is finally dropped, either through eviction or through another core's write. The data array, tag lookup, bus arbitration and the L2 are outside this block. The line index on each port is the result of a lookup done elsewhere.

All action outputs are combinational and belong to the current cycle. Line states are registered and change at the next clock edge. The `snp_hit` output tells the bus that this core holds a valid copy of a snooped read line. A requesting core's `peer_shared` input is the OR of its peers' `snp_hit` outputs.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. Each line state is a 3-bit field at `line_states[3i+2:3i]`, encoded Invalid=0, Shared=1, Exclusive=2, Owned=3, Modified=4, and no other value ever appears.
- R2: A local read (`lcl_op`=1) on an Invalid line raises `req_rd` in that cycle. The line becomes Exclusive if `peer_shared` is low and Shared if it is high. A local read on a valid line drives no action and leaves the state unchanged.
- R3: A local write (`lcl_op`=2) always leaves the line Modified. It raises `req_wr` when the line was Invalid, Shared or Owned. From Exclusive or Modified it raises no bus action.
- R4: A snooped read (`snp_op`=1) raises `snp_hit` when the line is valid. From Modified it raises `supply_data` and the line becomes Owned. From Owned it raises `supply_data` and the line stays Owned. Exclusive becomes Shared without a supply. Shared and Invalid are unchanged.
- R5: A snooped write (`snp_op`=2) leaves the line Invalid. It raises `wb_snoop` in the same cycle only when the line was Modified or Owned.
- R6: An eviction (`lcl_op`=3) leaves the line Invalid. It raises `wb_local` in the same cycle only when the line was Modified or Owned.
- R7: A transition drives at most one bus action. `req_rd` and `req_wr` are never high together, and `supply_data` is high only during a snooped read.
- R8: When a snooped transaction and a local operation name the same line in one cycle, the snoop is applied and the local operation is ignored. No `req_rd`, `req_wr` or `wb_local` is raised for it, and the line's next state is the one the snoop alone gives.
- R9: Across cores sharing a bus, at most one core holds a given line in Modified or Owned. A line held Modified or Exclusive has no other valid copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcl_op | input | 2 | Local operation: 0 none, 1 read, 2 write, 3 evict |
| lcl_idx | input | IDX_W | Line addressed by the local operation |
| peer_shared | input | 1 | Another core holds a valid copy of the line being read |
| snp_op | input | 2 | Snooped transaction: 0 none, 1 read, 2 write, 3 none |
| snp_idx | input | IDX_W | Line addressed by the snooped transaction |
| req_rd | output | 1 | Read notification to the bus |
| req_wr | output | 1 | Write notification to the bus |
| supply_data | output | 1 | This cache supplies the snooped line's data |
| snp_hit | output | 1 | A valid copy of the snooped read line is held here |
| wb_local | output | 1 | Writeback of the evicted line to L2 |
| wb_snoop | output | 1 | Writeback of the line invalidated by a snooped write |
| line_states | output | 3*LINES | Packed state of every line |

## Verification
The bench builds three controllers with `LINES`=4 on a modelled shared bus. Three cores make it possible to supply an Owned line to a second reader while a Shared copy already exists. They also allow a single write to invalidate one Owned and one Shared copy in the same cycle. Four lines let independent histories coexist, so states left behind by earlier scenarios are rechecked after every later step. The single-system invariant is evaluated on every line of every core after each step. A dedicated scenario places a local operation and a snoop on the same line.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        LOP_IDLE  = 2'd0,
        LOP_READ  = 2'd1,
        LOP_WRITE = 2'd2,
        LOP_EVICT = 2'd3
    } lcl_op_e;

    typedef enum logic [1:0] {
        SOP_IDLE  = 2'd0,
        SOP_READ  = 2'd1,
        SOP_WRITE = 2'd2,
        SOP_NONE  = 2'd3
    } snp_op_e;

    localparam int ST_W = 3;

    function automatic logic holds_dirty(line_st_e s);
        return (s == ST_M) || (s == ST_O);
    endfunction

endpackage

// File: rtl/moesi_local_next.sv
module moesi_local_next
    import moesi_pkg::*;
(
    input  line_st_e cur,
    input  lcl_op_e  op,
    input  logic     en,
    input  logic     peer_shared,
    input  logic     dirty,
    output line_st_e nxt,
    output logic     req_rd,
    output logic     req_wr,
    output logic     wb
);

    always_comb begin
        nxt    = cur;
        req_rd = 1'b0;
        req_wr = 1'b0;
        wb     = 1'b0;
        if (en) begin
            case (op)
                LOP_READ: begin
                    if (cur == ST_I) begin
                        req_rd = 1'b1;
                        nxt    = peer_shared ? ST_S : ST_E;
                    end
                end
                LOP_WRITE: begin
                    nxt = ST_M;
                    if (cur == ST_I || cur == ST_S || cur == ST_O) begin
                        req_wr = 1'b1;
                    end
                end
                LOP_EVICT: begin
                    nxt = ST_I;
                    wb  = dirty && holds_dirty(cur);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/moesi_snoop_next.sv
module moesi_snoop_next
    import moesi_pkg::*;
(
    input  line_st_e cur,
    input  snp_op_e  op,
    input  logic     dirty,
    output line_st_e nxt,
    output logic     supply,
    output logic     hit,
    output logic     wb
);

    always_comb begin
        nxt    = cur;
        supply = 1'b0;
        hit    = 1'b0;
        wb     = 1'b0;
        case (op)
            SOP_READ: begin
                hit = (cur != ST_I);
                case (cur)
                    ST_M: begin
                        supply = 1'b1;
                        nxt    = ST_O;
                    end
                    ST_O:    supply = 1'b1;
                    ST_E:    nxt    = ST_S;
                    default: ;
                endcase
            end
            SOP_WRITE: begin
                nxt = ST_I;
                wb  = dirty && holds_dirty(cur);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
    import moesi_pkg::*;
#(
    parameter  int LINES = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            lcl_op,
    input  logic [IDX_W-1:0]      lcl_idx,
    input  logic                  peer_shared,
    input  logic [1:0]            snp_op,
    input  logic [IDX_W-1:0]      snp_idx,
    output logic                  req_rd,
    output logic                  req_wr,
    output logic                  supply_data,
    output logic                  snp_hit,
    output logic                  wb_local,
    output logic                  wb_snoop,
    output logic [ST_W*LINES-1:0] line_states
);

    typedef struct packed {
        line_st_e [LINES-1:0] st;
        logic     [LINES-1:0] dirty;
    } ctl_t;

    ctl_t     ctl_d, ctl_q;
    lcl_op_e  lop;
    snp_op_e  sop;
    logic     snp_active;
    logic     lcl_en;
    line_st_e lcl_cur, lcl_nxt, snp_cur, snp_nxt;
    logic     lcl_dirty, snp_dirty;

    assign lop        = lcl_op_e'(lcl_op);
    assign sop        = snp_op_e'(snp_op);
    assign snp_active = (sop == SOP_READ) || (sop == SOP_WRITE);
    // same-line collision: the snoop wins, the local operation is dropped
    assign lcl_en     = !(snp_active && (lcl_idx == snp_idx));
    assign lcl_cur    = ctl_q.st[lcl_idx];
    assign lcl_dirty  = ctl_q.dirty[lcl_idx];
    assign snp_cur    = ctl_q.st[snp_idx];
    assign snp_dirty  = ctl_q.dirty[snp_idx];

    moesi_local_next u_local (
        .cur         (lcl_cur),
        .op          (lop),
        .en          (lcl_en),
        .peer_shared (peer_shared),
        .dirty       (lcl_dirty),
        .nxt         (lcl_nxt),
        .req_rd      (req_rd),
        .req_wr      (req_wr),
        .wb          (wb_local)
    );

    moesi_snoop_next u_snoop (
        .cur    (snp_cur),
        .op     (sop),
        .dirty  (snp_dirty),
        .nxt    (snp_nxt),
        .supply (supply_data),
        .hit    (snp_hit),
        .wb     (wb_snoop)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (lcl_en && (lop != LOP_IDLE)) begin
            ctl_d.st[lcl_idx] = lcl_nxt;
        end
        if (snp_active) begin
            ctl_d.st[snp_idx] = snp_nxt;
        end
        for (int i = 0; i < LINES; i++) begin
            case (ctl_d.st[i])
                ST_M:    ctl_d.dirty[i] = 1'b1;
                ST_O:    ctl_d.dirty[i] = ctl_q.dirty[i];
                default: ctl_d.dirty[i] = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st    <= {LINES{ST_I}};
            ctl_q.dirty <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign line_states = ctl_q.st;

endmodule

// File: rtl/moesi_line_ctrl_chk.sv
module moesi_line_ctrl_chk #(
    parameter  int LINES = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           lcl_op,
    input logic [IDX_W-1:0]     lcl_idx,
    input logic [1:0]           snp_op,
    input logic [IDX_W-1:0]     snp_idx,
    input logic                 req_rd,
    input logic                 req_wr,
    input logic                 supply_data,
    input logic                 wb_local,
    input logic                 wb_snoop,
    input logic [3*LINES-1:0]   line_states
);

    logic [IDX_W-1:0] lcl_idx_q, snp_idx_q;
    logic             collide;

    assign collide = (snp_op == 2'd1 || snp_op == 2'd2) && (lcl_idx == snp_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcl_idx_q <= '0;
            snp_idx_q <= '0;
        end else begin
            lcl_idx_q <= lcl_idx;
            snp_idx_q <= snp_idx;
        end
    end

    function automatic logic [2:0] st_at(logic [3*LINES-1:0] v, logic [IDX_W-1:0] i);
        return v[int'(i)*3 +: 3];
    endfunction

    for (genvar g = 0; g < LINES; g++) begin : gen_enc
        assert_enc_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
            line_states[g*3 +: 3] <= 3'd4);
    end

    assert_single_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_rd && req_wr));

    assert_supply_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        supply_data |-> (snp_op == 2'd1));

    assert_supply_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        supply_data |=> (st_at(line_states, snp_idx_q) == 3'd3));

    assert_snoop_write_inval_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_op == 2'd2) |=> (st_at(line_states, snp_idx_q) == 3'd0));

    assert_wb_needs_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_snoop |-> (snp_op == 2'd2));

    assert_wb_evict_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_local |-> (lcl_op == 2'd3));

    assert_write_to_mod_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_op == 2'd2 && !collide) |=> (st_at(line_states, lcl_idx_q) == 3'd4));

    assert_collision_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        collide |-> (!req_rd && !req_wr && !wb_local));

endmodule

bind moesi_line_ctrl moesi_line_ctrl_chk #(.LINES(LINES)) u_chk (.*);

// File: tb/test_moesi_line_ctrl.sv
`timescale 1ns/1ps
module test_moesi_line_ctrl;

    localparam int LINES = 4;
    localparam int NC    = 3;
    localparam int IW    = 2;
    localparam int OP_RD = 1, OP_WR = 2, OP_EV = 3;
    localparam int SI = 0, SS = 1, SE = 2, SO = 3, SM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [1:0]          lcl_op  [NC];
    logic [IW-1:0]       lcl_idx [NC];
    logic [1:0]          snp_op  [NC];
    logic [IW-1:0]       snp_idx [NC];
    logic                peer_sh [NC];
    logic                req_rd  [NC];
    logic                req_wr  [NC];
    logic                supply  [NC];
    logic                hit     [NC];
    logic                wbl     [NC];
    logic                wbs     [NC];
    logic [3*LINES-1:0]  states  [NC];

    int n_run  = 0;
    int n_fail = 0;
    int mst [NC][LINES];

    always_comb begin
        for (int j = 0; j < NC; j++) begin
            peer_sh[j] = 1'b0;
            for (int k = 0; k < NC; k++) begin
                if (k != j) peer_sh[j] = peer_sh[j] | hit[k];
            end
        end
    end

    for (genvar gk = 0; gk < NC; gk++) begin : gen_core
        moesi_line_ctrl #(.LINES(LINES)) i_moesi_line_ctrl (
            .clk         (clk),
            .rst_n       (rst_n),
            .lcl_op      (lcl_op[gk]),
            .lcl_idx     (lcl_idx[gk]),
            .peer_shared (peer_sh[gk]),
            .snp_op      (snp_op[gk]),
            .snp_idx     (snp_idx[gk]),
            .req_rd      (req_rd[gk]),
            .req_wr      (req_wr[gk]),
            .supply_data (supply[gk]),
            .snp_hit     (hit[gk]),
            .wb_local    (wbl[gk]),
            .wb_snoop    (wbs[gk]),
            .line_states (states[gk])
        );
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int st_of(int c, int l);
        return int'(states[c][l*3 +: 3]);
    endfunction

    function automatic bit owner(int s);
        return (s == SM) || (s == SO);
    endfunction

    task automatic idle_all();
        for (int k = 0; k < NC; k++) begin
            lcl_op[k] = '0; lcl_idx[k] = '0; snp_op[k] = '0; snp_idx[k] = '0;
        end
    endtask

    task automatic check_states(input string tag);
        for (int k = 0; k < NC; k++)
            for (int l = 0; l < LINES; l++)
                chk(st_of(k, l) == mst[k][l], tag, $sformatf("core%0d line%0d state", k, l),
                    st_of(k, l), mst[k][l]);
        // R9: system invariant over the actual states
        for (int l = 0; l < LINES; l++) begin
            int owners = 0, valid = 0, excl = 0;
            for (int k = 0; k < NC; k++) begin
                if (owner(st_of(k, l))) owners++;
                if (st_of(k, l) != SI) valid++;
                if (st_of(k, l) == SM || st_of(k, l) == SE) excl++;
            end
            chk(owners <= 1, "R9", $sformatf("line%0d owner count", l), owners, 1);
            chk(excl == 0 || valid == 1, "R9", $sformatf("line%0d copies beside M/E", l), valid, 1);
        end
    endtask

    // one local operation by core c, with the bus effect seen by every peer
    task automatic do_op(input int c, input int op, input int idx, input string tag);
        int  bus = 0;
        int  cur;
        bit  others_valid = 1'b0;
        @(negedge clk);
        cur = mst[c][idx];
        for (int k = 0; k < NC; k++)
            if (k != c && mst[k][idx] != SI) others_valid = 1'b1;
        if (op == OP_RD && cur == SI) bus = 1;
        if (op == OP_WR && (cur == SI || cur == SS || cur == SO)) bus = 2;
        lcl_op[c]  = 2'(op);
        lcl_idx[c] = IW'(idx);
        for (int k = 0; k < NC; k++) begin
            if (k != c) begin
                snp_op[k]  = 2'(bus);
                snp_idx[k] = IW'(idx);
            end
        end
        #1;
        chk(req_rd[c] == (bus == 1), tag, "req_rd", int'(req_rd[c]), int'(bus == 1));
        chk(req_wr[c] == (bus == 2), tag, "req_wr", int'(req_wr[c]), int'(bus == 2));
        chk(!(req_rd[c] && req_wr[c]), "R7", "two notifications", 1, 0);
        chk(wbl[c] == (op == OP_EV && owner(cur)), "R6", "wb_local",
            int'(wbl[c]), int'(op == OP_EV && owner(cur)));
        for (int k = 0; k < NC; k++) begin
            if (k != c) begin
                chk(supply[k] == (bus == 1 && owner(mst[k][idx])), "R4",
                    $sformatf("core%0d supply", k), int'(supply[k]),
                    int'(bus == 1 && owner(mst[k][idx])));
                chk(hit[k] == (bus == 1 && mst[k][idx] != SI), "R4",
                    $sformatf("core%0d snp_hit", k), int'(hit[k]),
                    int'(bus == 1 && mst[k][idx] != SI));
                chk(wbs[k] == (bus == 2 && owner(mst[k][idx])), "R5",
                    $sformatf("core%0d wb_snoop", k), int'(wbs[k]),
                    int'(bus == 2 && owner(mst[k][idx])));
            end
        end
        // reference update
        for (int k = 0; k < NC; k++) begin
            if (k != c) begin
                if (bus == 1 && mst[k][idx] == SM) mst[k][idx] = SO;
                if (bus == 1 && mst[k][idx] == SE) mst[k][idx] = SS;
                if (bus == 2) mst[k][idx] = SI;
            end
        end
        if (op == OP_RD && cur == SI) mst[c][idx] = others_valid ? SS : SE;
        if (op == OP_WR) mst[c][idx] = SM;
        if (op == OP_EV) mst[c][idx] = SI;
        @(posedge clk);
        #1;
        idle_all();
        check_states(tag);
    endtask

    task automatic t_reset();
        #1;
        for (int k = 0; k < NC; k++)
            chk(states[k] == '0, "R1", $sformatf("core%0d state in reset", k), int'(states[k]), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_states("R1");
        chk(!req_rd[0] && !req_wr[0] && !supply[0] && !wbl[0] && !wbs[0], "R1",
            "idle outputs", 0, 0);
    endtask

    task automatic t_read_paths();
        do_op(0, OP_RD, 0, "R2");   // I -> E, no peer copy
        do_op(0, OP_RD, 0, "R2");   // hit, silent
        do_op(0, OP_WR, 0, "R3");   // E -> M, silent
    endtask

    task automatic t_owned_supply();
        do_op(1, OP_RD, 0, "R4");   // peer M supplies, becomes O; reader S
        do_op(2, OP_RD, 0, "R4");   // O supplies again, stays O
    endtask

    task automatic t_upgrade();
        do_op(1, OP_WR, 0, "R3");   // S -> M with notification, O and S copies dropped
    endtask

    task automatic t_evictions();
        do_op(1, OP_EV, 0, "R6");   // M evicted with writeback
        do_op(2, OP_RD, 1, "R2");   // E
        do_op(2, OP_EV, 1, "R6");   // E evicted, no writeback
        do_op(0, OP_WR, 2, "R3");   // I -> M with notification
        do_op(1, OP_RD, 2, "R4");   // owner keeps dirty copy
        do_op(0, OP_EV, 2, "R6");   // O evicted with writeback
        do_op(1, OP_WR, 2, "R3");   // S -> M
    endtask

    task automatic t_shared_from_excl();
        do_op(0, OP_RD, 3, "R2");   // E
        do_op(1, OP_RD, 3, "R2");   // peer E -> S, reader S
    endtask

    task automatic t_owned_write();
        do_op(0, OP_WR, 1, "R3");
        do_op(1, OP_RD, 1, "R4");
        do_op(0, OP_WR, 1, "R3");   // O -> M with notification
    endtask

    task automatic t_collision();
        // eviction and snooped write on the same Modified line
        @(negedge clk);
        lcl_op[0] = 2'(OP_EV); lcl_idx[0] = 2'd1;
        snp_op[0] = 2'd2;      snp_idx[0] = 2'd1;
        #1;
        chk(!wbl[0], "R8", "wb_local on collision", int'(wbl[0]), 0);
        chk(wbs[0], "R8", "wb_snoop on collision", int'(wbs[0]), 1);
        @(posedge clk);
        #1;
        idle_all();
        mst[0][1] = SI;
        check_states("R8");
        // write and snooped read on the same Shared line
        @(negedge clk);
        lcl_op[0] = 2'(OP_WR); lcl_idx[0] = 2'd3;
        snp_op[0] = 2'd1;      snp_idx[0] = 2'd3;
        #1;
        chk(!req_wr[0], "R8", "req_wr on collision", int'(req_wr[0]), 0);
        chk(hit[0], "R8", "snp_hit on collision", int'(hit[0]), 1);
        chk(!supply[0], "R8", "supply on collision", int'(supply[0]), 0);
        @(posedge clk);
        #1;
        idle_all();
        check_states("R8");     // line 3 stays Shared
    endtask

    initial begin
        #800000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < NC; k++)
            for (int l = 0; l < LINES; l++) mst[k][l] = SI;
        idle_all();
        t_reset();
        t_read_paths();
        t_owned_supply();
        t_upgrade();
        t_evictions();
        t_shared_from_excl();
        t_owned_write();
        t_collision();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule